// File: doc/BRIEF.md
# Stack-Operand Floating Instruction Sequencer

This block carries out a small group of two-operand floating-point instructions. Both operands are held on a stack in memory, and a general register points to that stack. An accepted instruction word is decoded, and the register it names gives the stack pointer. The block fetches two 32-bit operands, each as two 16-bit words, through a single-outstanding memory port. It passes them with an operation code to an external arithmetic unit over a request/acknowledge handshake. The result replaces the deeper stack operand, and the block then reports the condition codes.

The operand near the top of the stack (B) is at pointer+0 and pointer+2. The deeper operand (A) is at pointer+4 and pointer+6. The operation is always A op B. A result too small to represent is stored as zero. A divide whose divisor is zero writes nothing. An encoding outside the supported set raises a reserved-instruction trap request and performs no memory access.

Top module: `fstk_seq`

## Requirements
- R1: An instruction is supported when its upper ten bits are 0111101000 and bit 5 is 0. Bits 4:3 select the operation, with 0 add, 1 subtract, 2 multiply and 3 divide, and this value appears on `alu_op`. Bits 2:0 select the register on `rf_sel`. The value on `rf_data` at acceptance becomes the byte pointer.
- R2: A supported instruction makes four reads, in the order pointer+0, +2, +4, +6. Each read holds its request, address and direction until `mem_ready` is sampled high. B is {word@+0, word@+2} and A is {word@+4, word@+6}, with the first word of each pair as the upper half.
- R3: After the reads, `alu_req` rises with `alu_a` = A and `alu_b` = B. It holds, with those values stable, until `alu_ack` is sampled high.
- R4: The result is written as two words: the upper half to pointer+4, then the lower half to pointer+6. The words at pointer+0 and pointer+2 are never written.
- R5: A result whose exponent field (bits 30:23) is zero is stored as 32'h0, including its sign bit. Any other result is stored unchanged.
- R6: When a result has been stored, `cc_we` pulses together with `done`. `cc_n` is then bit 31 of the stored value, `cc_z` is 1 when the stored value is zero, and `cc_v` and `cc_c` are 0.
- R7: A divide whose B exponent field is zero makes no arithmetic request and no write. The condition code outputs stay unchanged and `cc_we` stays low, but `done` still pulses.
- R8: An accepted unsupported instruction pulses `trap` with `done` and makes no memory access. It leaves the condition codes unchanged. `trap_vec` reads 8 (octal 10).
- R9: `done` is high for exactly one cycle per instruction. `instr_valid` is ignored while `idle` is low.
- R10: After reset, `idle` is 1 and `mem_req`, `alu_req`, `done`, `trap` and all condition code outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present |
| instr | input | 16 | Instruction word |
| idle | output | 1 | Ready to accept an instruction |
| rf_sel | output | 3 | Register file read select |
| rf_data | input | AW | Selected register value (stack pointer) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | WW | Write data word |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | WW | Read data word |
| alu_req | output | 1 | Arithmetic request |
| alu_op | output | 2 | Operation code |
| alu_a | output | 2*WW | Operand A |
| alu_b | output | 2*WW | Operand B |
| alu_ack | input | 1 | Arithmetic result valid |
| alu_res | input | 2*WW | Arithmetic result |
| done | output | 1 | Instruction finished (one cycle) |
| trap | output | 1 | Reserved-instruction trap request |
| trap_vec | output | AW | Trap vector address |
| cc_we | output | 1 | Condition code update strobe |
| cc_n | output | 1 | Negative flag |
| cc_z | output | 1 | Zero flag |
| cc_v | output | 1 | Overflow flag |
| cc_c | output | 1 | Carry flag |

## Verification
The stimulus covers every value of the operation field together with every register field, under four result and divisor patterns. These are a positive normal result, a negative normal result, a signed result with a zero exponent, and an all-zero result with a zero-exponent divisor. Comparing them separates a plain pass-through from the flush-to-zero rule and the sign handling of the flags, and it shows that a zero divisor aborts only the divide. Memory and arithmetic latencies vary from run to run, which shows up any access that moves before its handshake. Added cases cover encodings outside the group, a pointer that wraps past the top of the address space, and an instruction offered while the block is busy.

// File: rtl/fstk_pkg.sv
package fstk_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_CHECK,
    S_CALC,
    S_WRITE
  } fstk_state_t;

  localparam logic [9:0] GROUP_CODE = 10'b0111101000;
  localparam logic [1:0] OP_DIV     = 2'd3;
endpackage

// File: rtl/fstk_decode.sv
module fstk_decode
  import fstk_pkg::*;
(
  input  logic [15:0] instr,
  output logic        supported,
  output logic [1:0]  op,
  output logic [2:0]  rsel
);
  assign rsel      = instr[2:0];
  assign op        = instr[4:3];
  assign supported = (instr[15:6] == GROUP_CODE) && !instr[5];
endmodule

// File: rtl/fstk_post.sv
module fstk_post #(
  parameter int DW    = 32,
  parameter int EXP_W = 8
) (
  input  logic [DW-1:0] res,
  output logic [DW-1:0] stored,
  output logic          neg,
  output logic          zero
);
  localparam int EXP_MSB = DW - 2;

  always_comb begin
    zero   = (res[EXP_MSB -: EXP_W] == '0);
    stored = zero ? '0 : res;
    neg    = stored[DW-1];
  end
endmodule

// File: rtl/fstk_seq.sv
module fstk_seq
  import fstk_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          WW       = 16,
  parameter int          EXP_W    = 8,
  parameter logic [15:0] TRAP_VEC = 16'o10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_valid,
  input  logic [15:0]     instr,
  output logic            idle,
  output logic [2:0]      rf_sel,
  input  logic [AW-1:0]   rf_data,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [WW-1:0]   mem_wdata,
  input  logic            mem_ready,
  input  logic [WW-1:0]   mem_rdata,
  output logic            alu_req,
  output logic [1:0]      alu_op,
  output logic [2*WW-1:0] alu_a,
  output logic [2*WW-1:0] alu_b,
  input  logic            alu_ack,
  input  logic [2*WW-1:0] alu_res,
  output logic            done,
  output logic            trap,
  output logic [AW-1:0]   trap_vec,
  output logic            cc_we,
  output logic            cc_n,
  output logic            cc_z,
  output logic            cc_v,
  output logic            cc_c
);
  localparam int          DW   = 2 * WW;
  localparam logic [AW-1:0] STEP = AW'(WW / 8);

  fstk_state_t   state;
  logic [1:0]    idx;
  logic [AW-1:0] ptr;
  logic [1:0]    op_q;
  logic [DW-1:0] opa, opb, res_q;
  logic          n_q, z_q;

  logic          dec_ok;
  logic [1:0]    dec_op;
  logic [DW-1:0] post_res;
  logic          post_n, post_z;
  logic          b_zero;

  fstk_decode u_dec (
    .instr     (instr),
    .supported (dec_ok),
    .op        (dec_op),
    .rsel      (rf_sel)
  );

  fstk_post #(.DW(DW), .EXP_W(EXP_W)) u_post (
    .res    (alu_res),
    .stored (post_res),
    .neg    (post_n),
    .zero   (post_z)
  );

  assign b_zero   = (opb[DW-2 -: EXP_W] == '0);
  assign idle     = (state == S_IDLE);
  assign alu_a    = opa;
  assign alu_b    = opb;
  assign alu_op   = op_q;
  assign trap_vec = AW'(TRAP_VEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      idx       <= '0;
      ptr       <= '0;
      op_q      <= '0;
      opa       <= '0;
      opb       <= '0;
      res_q     <= '0;
      n_q       <= 1'b0;
      z_q       <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      alu_req   <= 1'b0;
      done      <= 1'b0;
      trap      <= 1'b0;
      cc_we     <= 1'b0;
      cc_n      <= 1'b0;
      cc_z      <= 1'b0;
      cc_v      <= 1'b0;
      cc_c      <= 1'b0;
    end else begin
      done  <= 1'b0;
      trap  <= 1'b0;
      cc_we <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (instr_valid) begin
            if (dec_ok) begin
              op_q     <= dec_op;
              ptr      <= rf_data;
              mem_addr <= rf_data;
              mem_we   <= 1'b0;
              mem_req  <= 1'b1;
              idx      <= '0;
              state    <= S_READ;
            end else begin
              trap <= 1'b1;
              done <= 1'b1;
            end
          end
        end
        S_READ: begin
          if (mem_ready) begin
            unique case (idx)
              2'd0: opb[DW-1:WW] <= mem_rdata;
              2'd1: opb[WW-1:0]  <= mem_rdata;
              2'd2: opa[DW-1:WW] <= mem_rdata;
              default: opa[WW-1:0] <= mem_rdata;
            endcase
            if (idx == 2'd3) begin
              mem_req <= 1'b0;
              state   <= S_CHECK;
            end else begin
              idx      <= idx + 2'd1;
              mem_addr <= mem_addr + STEP;
            end
          end
        end
        S_CHECK: begin
          if (op_q == OP_DIV && b_zero) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            alu_req <= 1'b1;
            state   <= S_CALC;
          end
        end
        S_CALC: begin
          if (alu_ack) begin
            alu_req   <= 1'b0;
            res_q     <= post_res;
            n_q       <= post_n;
            z_q       <= post_z;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= ptr + (STEP << 1);
            mem_wdata <= post_res[DW-1:WW];
            idx       <= '0;
            state     <= S_WRITE;
          end
        end
        S_WRITE: begin
          if (mem_ready) begin
            if (idx == 2'd0) begin
              idx       <= 2'd1;
              mem_addr  <= mem_addr + STEP;
              mem_wdata <= res_q[WW-1:0];
            end else begin
              mem_req <= 1'b0;
              mem_we  <= 1'b0;
              done    <= 1'b1;
              cc_we   <= 1'b1;
              cc_n    <= n_q;
              cc_z    <= z_q;
              cc_v    <= 1'b0;
              cc_c    <= 1'b0;
              state   <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fstk_seq_chk.sv
module fstk_seq_chk #(
  parameter int AW = 16,
  parameter int WW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            idle,
  input logic            mem_req,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic [WW-1:0]   mem_wdata,
  input logic            mem_ready,
  input logic            alu_req,
  input logic [1:0]      alu_op,
  input logic [2*WW-1:0] alu_a,
  input logic [2*WW-1:0] alu_b,
  input logic            alu_ack,
  input logic            done,
  input logic            trap,
  input logic            cc_we,
  input logic            cc_n,
  input logic            cc_z,
  input logic            cc_v,
  input logic            cc_c
);
  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R3
  alu_hold_chk: assert property (@(posedge clk) disable iff (rst)
    alu_req && !alu_ack |=> alu_req && $stable(alu_op) && $stable(alu_a) && $stable(alu_b));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    idle |-> !mem_req && !alu_req);

  // R6
  cc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cc_we |-> done && !cc_v && !cc_c);

  // R5
  zero_sign_chk: assert property (@(posedge clk) disable iff (rst)
    cc_we && cc_z |-> !cc_n);

  // R8
  trap_done_chk: assert property (@(posedge clk) disable iff (rst)
    trap |-> done && !cc_we);
endmodule

bind fstk_seq fstk_seq_chk #(.AW(AW), .WW(WW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .idle      (idle),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready),
  .alu_req   (alu_req),
  .alu_op    (alu_op),
  .alu_a     (alu_a),
  .alu_b     (alu_b),
  .alu_ack   (alu_ack),
  .done      (done),
  .trap      (trap),
  .cc_we     (cc_we),
  .cc_n      (cc_n),
  .cc_z      (cc_z),
  .cc_v      (cc_v),
  .cc_c      (cc_c)
);

// File: tb/tb_fstk_seq.sv
module tb_fstk_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = 16'h0;
  logic        idle;
  logic [2:0]  rf_sel;
  logic [15:0] rf_data;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_rdata;
  logic        alu_req;
  logic [1:0]  alu_op;
  logic [31:0] alu_a, alu_b;
  logic        alu_ack = 1'b0;
  logic [31:0] alu_res;
  logic        done, trap;
  logic [15:0] trap_vec;
  logic        cc_we, cc_n, cc_z, cc_v, cc_c;

  always #4 clk = ~clk;

  fstk_seq dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr), .idle(idle),
    .rf_sel(rf_sel), .rf_data(rf_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .alu_req(alu_req), .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b),
    .alu_ack(alu_ack), .alu_res(alu_res),
    .done(done), .trap(trap), .trap_vec(trap_vec),
    .cc_we(cc_we), .cc_n(cc_n), .cc_z(cc_z), .cc_v(cc_v), .cc_c(cc_c)
  );

  int checks = 0;
  int errors = 0;

  // register file and memory models
  logic [15:0] rf [8];
  logic [15:0] mem [64];
  logic        set_we = 1'b0;
  logic [5:0]  set_idx = 6'd0;
  logic [15:0] set_data = 16'h0;
  assign rf_data   = rf[rf_sel];
  assign mem_rdata = mem[mem_addr[6:1]];

  always @(posedge clk) begin
    if (set_we) mem[set_idx] <= set_data;
    else if (mem_req && mem_ready && mem_we) mem[mem_addr[6:1]] <= mem_wdata;
  end

  int          nacc = 0;
  logic [15:0] log_addr [64];
  logic        log_we   [64];
  always @(posedge clk) begin
    if (!rst && mem_req && mem_ready) begin
      log_addr[nacc & 63] <= mem_addr;
      log_we[nacc & 63]   <= mem_we;
      nacc <= nacc + 1;
    end
  end

  int mem_lat = 0;
  int tick = 0;
  always @(negedge clk) begin
    tick <= tick + 1;
    mem_ready <= mem_req && ((tick % (mem_lat + 1)) == 0);
  end

  // arithmetic unit model: returns a bench-chosen value
  logic [31:0] alu_ret = 32'h0;
  int          alu_lat = 0;
  int          alu_wait = 0;
  int          nalu = 0;
  logic [1:0]  got_op = 2'd0;
  logic [31:0] got_a = 32'h0, got_b = 32'h0;
  assign alu_res = alu_ret;
  always @(negedge clk) begin
    alu_wait <= alu_req ? alu_wait + 1 : 0;
    alu_ack  <= alu_req && (alu_wait >= alu_lat);
  end
  always @(posedge clk) begin
    if (!rst && alu_req && alu_ack) begin
      nalu   <= nalu + 1;
      got_op <= alu_op;
      got_a  <= alu_a;
      got_b  <= alu_b;
    end
  end

  logic model_n = 1'b0, model_z = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic setw(input logic [15:0] addr, input logic [15:0] data);
    @(negedge clk);
    set_we = 1'b1; set_idx = addr[6:1]; set_data = data;
    @(negedge clk);
    set_we = 1'b0;
  endtask

  task automatic run(input logic [15:0] ins, input logic [15:0] p, input logic [31:0] a,
                     input logic [31:0] b, input logic [31:0] ret, input int ml,
                     input int al, input bit poke);
    bit ok, dz, stores, trap_seen;
    int n0, a0, cyc;
    logic [31:0] fl;
    logic        s_we, s_n, s_z, s_v, s_c, s_trap;
    ok = (ins[15:6] == 10'b0111101000) && !ins[5];
    dz = ok && (ins[4:3] == 2'd3) && (b[30:23] == 8'd0);
    stores = ok && !dz;
    fl = (ret[30:23] == 8'd0) ? 32'h0 : ret;
    rf[ins[2:0]] = p;
    mem_lat = ml; alu_lat = al; alu_ret = ret;
    setw(p, b[31:16]);
    setw(p + 16'd2, b[15:0]);
    setw(p + 16'd4, a[31:16]);
    setw(p + 16'd6, a[15:0]);
    @(negedge clk);
    n0 = nacc; a0 = nalu;
    instr = ins; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    cyc = 0;
    trap_seen = 1'b0;
    while (!done && cyc < 400) begin
      if (trap) trap_seen = 1'b1;
      if (poke && cyc == 2) begin
        instr = 16'hFFFF; instr_valid = 1'b1;
      end else instr_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    instr_valid = 1'b0;
    chk("R9 done seen", {31'd0, done}, 32'd1);
    s_we = cc_we; s_n = cc_n; s_z = cc_z; s_v = cc_v; s_c = cc_c; s_trap = trap;
    @(negedge clk);
    chk("R9 done one cycle", {31'd0, done}, 32'd0);
    chk("R9 back to idle", {31'd0, idle}, 32'd1);
    chk("R8 trap flag", {31'd0, s_trap}, {31'd0, !ok});
    if (poke) chk("R9 busy instr ignored", {31'd0, trap_seen | trap}, 32'd0);
    if (!ok) chk("R8 trap vector", {16'd0, trap_vec}, 32'd8);
    chk("R2 R4 access count", nacc - n0, ok ? (dz ? 4 : 6) : 0);
    chk("R7 R3 alu request count", nalu - a0, stores ? 1 : 0);
    if (ok) begin
      for (int k = 0; k < 4; k++) begin
        chk("R2 read address", {16'd0, log_addr[(n0 + k) & 63]}, {16'd0, p + 16'(2 * k)});
        chk("R2 read direction", {31'd0, log_we[(n0 + k) & 63]}, 32'd0);
      end
    end
    if (stores) begin
      chk("R4 first write addr", {16'd0, log_addr[(n0 + 4) & 63]}, {16'd0, p + 16'd4});
      chk("R4 second write addr", {16'd0, log_addr[(n0 + 5) & 63]}, {16'd0, p + 16'd6});
      chk("R4 write direction", {31'd0, log_we[(n0 + 5) & 63]}, 32'd1);
      chk("R1 alu op", {30'd0, got_op}, {30'd0, ins[4:3]});
      chk("R3 operand A", got_a, a);
      chk("R3 operand B", got_b, b);
    end
    chk("R4 B words kept", {mem[p[6:1]], mem[6'(p[6:1] + 6'd1)]}, b);
    chk("R5 R7 stored A slot", {mem[6'(p[6:1] + 6'd2)], mem[6'(p[6:1] + 6'd3)]}, stores ? fl : a);
    chk("R6 R7 cc strobe", {31'd0, s_we}, {31'd0, stores});
    if (stores) begin
      model_n = fl[31];
      model_z = (fl == 32'h0);
      chk("R6 V C clear", {30'd0, s_v, s_c}, 32'd0);
    end
    chk("R6 R7 R8 cc N", {31'd0, s_n}, {31'd0, model_n});
    chk("R6 R7 R8 cc Z", {31'd0, s_z}, {31'd0, model_z});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rets [4];
    logic [31:0] bs [4];
    rets[0] = 32'h40C0_1234; rets[1] = 32'hC123_4567;
    rets[2] = 32'h807F_FFFF; rets[3] = 32'h0000_0000;
    bs[0] = 32'h0080_1111; bs[1] = 32'h4100_2222;
    bs[2] = 32'h0000_5555; bs[3] = 32'h0000_0000;
    for (int i = 0; i < 8; i++) rf[i] = 16'h0;
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 idle", {31'd0, idle}, 32'd1);
    chk("R10 requests", {30'd0, mem_req, alu_req}, 32'd0);
    chk("R10 done trap", {30'd0, done, trap}, 32'd0);
    chk("R10 cc", {28'd0, cc_n, cc_z, cc_v, cc_c}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 idle after release", {31'd0, idle}, 32'd1);

    // R1 R5 R6 R7 R8 sweep over operation, register and pattern
    for (int op = 0; op < 8; op++)
      for (int r = 0; r < 8; r++)
        for (int pat = 0; pat < 4; pat++)
          run({10'b0111101000, 3'(op), 3'(r)}, 16'h0010 + 16'(r * 16),
              {16'h4100 + 16'(r), 16'h2000 + 16'(pat)}, bs[pat], rets[pat],
              (op + r) % 3, pat % 3, 1'b0);

    // R8 encodings outside the group
    run(16'h0000, 16'h0020, 32'h4111_0001, 32'h4222_0002, rets[0], 0, 0, 1'b0);
    run(16'o074000, 16'h0020, 32'h4111_0003, 32'h4222_0004, rets[0], 1, 0, 1'b0);
    run(16'o075300, 16'h0020, 32'h4111_0005, 32'h4222_0006, rets[0], 0, 1, 1'b0);
    // R2 R4 pointer wrapping past the top of the address space
    run(16'o075001, 16'hFFFC, 32'h4333_0007, 32'h4444_0008, rets[1], 2, 1, 1'b0);
    // R9 instruction offered while busy
    run(16'o075012, 16'h0040, 32'h4555_0009, 32'h4666_000A, rets[0], 2, 2, 1'b1);
    // R7 divide with zero divisor after a negative result
    run(16'o075003, 16'h0030, 32'h4777_000B, 32'h4888_000C, rets[1], 0, 0, 1'b0);
    run(16'o075033, 16'h0030, 32'h4777_000D, 32'h0000_0001, rets[0], 1, 0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule